// File: doc/BRIEF.md
# Strobe-Gated Serial PCM Port

This block moves 8-bit companded voice samples between a codec core and a bit-serial bus. The bus carries a bit clock, a serial input line, a serial output line with a separate drive enable, and a strobe that marks the channel's time slot. The port only acts inside a strobe window. Each window carries one byte in each direction, most significant bit first. Outside the window the output is not driven.

All bus inputs are brought into the block's system clock through a short synchronizer, and bus events come from edges of the synchronized signals. A mode input picks the latency. In synchronous mode the byte sent in a window is the core byte present when the window opens, and the byte received in a window goes straight to the core. In asynchronous mode a one-window holding register sits in each direction, so the core sample rate and the bus timing need not be related. This mode covers bus rates such as 128 kb/s and 256 kb/s. A mute input replaces the outgoing sample with the quiet code of the selected companding law.

Top module: `pcm_strobe_port`

## Requirements
- R1: The serial input is sampled on each falling bit-clock edge inside a strobe window, and the bits are assembled most significant bit first.
- R2: The output bit advances only on rising bit-clock edges inside a window. The first bit shown in a window is bit 7 of the outgoing byte, then bit 6, and so on down to bit 0.
- R3: The drive enable `doutEn` is 0, and `dout` is 0, whenever the strobe is inactive. The enable follows the strobe input after SYNC_STAGES+1 clock cycles.
- R4: In synchronous mode (`asyncMode`=0), a window sends the `txByte` present when the window opens and delivers that same window's received byte.
- R5: In asynchronous mode (`asyncMode`=1), both directions are delayed by exactly one window. The byte sent is the `txByte` captured at the previous window's opening, and the byte delivered is the one received in the previous complete window.
- R6: When `txMute`=1 at the opening of a window, that window sends the quiet code. The quiet code is 0xFF when `aLaw`=0 and 0xD5 when `aLaw`=1. In asynchronous mode the holding register still captures `txByte`.
- R7: Only the first 8 bits of a window count. Later input bits are ignored, and later output bits are 1 (the quiet code's bit 0).
- R8: `rxValid` is a one-cycle pulse that follows the close of a window with at least 8 received bits. A shorter window gives no pulse, and in asynchronous mode it leaves the receive holding register unchanged.
- R9: While `rst` is held, `doutEn` and `rxValid` are 0, and every shift and holding register, including `rxByte`, takes the quiet code of the current `aLaw`. As a result, the first asynchronous window after reset sends and delivers the quiet code.
- R10: `rxByte` changes only in the cycle in which `rxValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Bus bit clock |
| stb | input | 1 | Time-slot strobe, active high |
| din | input | 1 | Serial data from the bus |
| asyncMode | input | 1 | 0: no window delay, 1: one window of delay |
| aLaw | input | 1 | Companding law select for the quiet code (1 selects A-law) |
| txMute | input | 1 | Send the quiet code in the next window |
| txByte | input | 8 | Sample from the core for transmission |
| dout | output | 1 | Serial data to the bus |
| doutEn | output | 1 | Drive enable for `dout` (0 means high impedance) |
| rxByte | output | 8 | Last byte delivered to the core |
| rxValid | output | 1 | One-cycle pulse when `rxByte` is updated |

## Verification
The assertions check the timing rules on every cycle. The enable follows the strobe after its fixed latency. The output bit changes only after the bit clock has gone high. `rxValid` lasts one cycle and never overlaps a driven window. `rxByte` holds between pulses. Reset forces the idle state. Some behaviour can only be shown by the bench's scenarios, because it depends on byte values across whole windows: the bit order, the zero and one window latency, mute under each law, the bits past the eighth, the discarding of a partial window, and the quiet contents of the holding registers after reset.

// File: rtl/pcm_strobe_pkg.sv
package pcm_strobe_pkg;

  localparam int SAMPLE_W = 8;

  typedef logic [SAMPLE_W-1:0] sample_t;

  localparam sample_t QUIET_MU = 8'hFF;
  localparam sample_t QUIET_A  = 8'hD5;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic drive;     // output driver enabled
    logic loadTx;    // window opened: load transmit shifter
    logic shiftTx;   // rising bit clock after a sampled bit: advance output
    logic sampleRx;  // falling bit clock: take one input bit
    logic closeOk;   // window closed with a full byte received
    logic rxBit;     // synchronized input bit
  } portCtl_t;

  function automatic sample_t quietCode(input logic aLawSel);
    return aLawSel ? QUIET_A : QUIET_MU;
  endfunction

endpackage

// File: rtl/pcm_strobe_ctrl.sv
module pcm_strobe_ctrl
  import pcm_strobe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BITS        = SAMPLE_W
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bclk,
  input  logic     stb,
  input  logic     din,
  output portCtl_t ctl
);

  localparam int CNT_W = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BITS);

  logic [SYNC_STAGES:0]   bclkPipe;
  logic [SYNC_STAGES:0]   stbPipe;
  logic [SYNC_STAGES-1:0] dinPipe;
  logic [CNT_W-1:0]       rxCount;
  logic                   bitTaken;

  logic bclkNow, bclkPrev, stbNow, stbPrev;
  logic bclkRise, bclkFall, stbRise, stbFall;

  assign bclkNow  = bclkPipe[SYNC_STAGES-1];
  assign bclkPrev = bclkPipe[SYNC_STAGES];
  assign stbNow   = stbPipe[SYNC_STAGES-1];
  assign stbPrev  = stbPipe[SYNC_STAGES];

  assign bclkRise = bclkNow & ~bclkPrev;
  assign bclkFall = ~bclkNow & bclkPrev;
  assign stbRise  = stbNow & ~stbPrev;
  assign stbFall  = ~stbNow & stbPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclkPipe <= '0;
      stbPipe  <= '0;
      dinPipe  <= '0;
    end else begin
      bclkPipe <= {bclkPipe[SYNC_STAGES-1:0], bclk};
      stbPipe  <= {stbPipe[SYNC_STAGES-1:0], stb};
      dinPipe  <= {dinPipe[SYNC_STAGES-2:0], din};
    end
  end

  // bit bookkeeping inside one window
  always_ff @(posedge clk) begin
    if (rst) begin
      rxCount  <= '0;
      bitTaken <= 1'b0;
    end else if (stbRise) begin
      rxCount  <= '0;
      bitTaken <= 1'b0;
    end else if (stbNow) begin
      if (bclkFall) begin
        bitTaken <= 1'b1;
        if (rxCount != FULL) rxCount <= rxCount + 1'b1;
      end else if (bclkRise) begin
        bitTaken <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.drive    = stbPrev;
    ctl.loadTx   = stbRise;
    ctl.shiftTx  = stbNow & ~stbRise & bclkRise & bitTaken;
    ctl.sampleRx = stbNow & ~stbRise & bclkFall & (rxCount != FULL);
    ctl.closeOk  = stbFall & (rxCount == FULL);
    ctl.rxBit    = dinPipe[SYNC_STAGES-1];
  end

endmodule

// File: rtl/pcm_strobe_dp.sv
module pcm_strobe_dp
  import pcm_strobe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  portCtl_t ctl,
  input  logic     asyncMode,
  input  logic     aLaw,
  input  logic     txMute,
  input  sample_t  txByte,
  output logic     dout,
  output logic     doutEn,
  output sample_t  rxByte,
  output logic     rxValid
);

  sample_t txShift, txHold, rxShift, rxHold, quiet;

  assign quiet = quietCode(aLaw);

  // transmit side
  always_ff @(posedge clk) begin
    if (rst) begin
      txShift <= quiet;
      txHold  <= quiet;
    end else if (ctl.loadTx) begin
      txHold <= txByte;
      if (txMute)         txShift <= quiet;
      else if (asyncMode) txShift <= txHold;
      else                txShift <= txByte;
    end else if (ctl.shiftTx) begin
      txShift <= {txShift[SAMPLE_W-2:0], quiet[0]};
    end
  end

  // receive side
  always_ff @(posedge clk) begin
    if (rst) begin
      rxShift <= quiet;
      rxHold  <= quiet;
      rxByte  <= quiet;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (ctl.sampleRx) rxShift <= {rxShift[SAMPLE_W-2:0], ctl.rxBit};
      if (ctl.closeOk) begin
        rxHold  <= rxShift;
        rxByte  <= asyncMode ? rxHold : rxShift;
        rxValid <= 1'b1;
      end
    end
  end

  assign doutEn = ctl.drive;
  assign dout   = ctl.drive & txShift[SAMPLE_W-1];

endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
  import pcm_strobe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk,
  input  logic                stb,
  input  logic                din,
  input  logic                asyncMode,
  input  logic                aLaw,
  input  logic                txMute,
  input  logic [SAMPLE_W-1:0] txByte,
  output logic                dout,
  output logic                doutEn,
  output logic [SAMPLE_W-1:0] rxByte,
  output logic                rxValid
);

  portCtl_t ctl;

  pcm_strobe_ctrl #(.SYNC_STAGES(SYNC_STAGES), .BITS(SAMPLE_W)) u_ctrl (
    .clk (clk),
    .rst (rst),
    .bclk(bclk),
    .stb (stb),
    .din (din),
    .ctl (ctl)
  );

  pcm_strobe_dp u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .asyncMode(asyncMode),
    .aLaw     (aLaw),
    .txMute   (txMute),
    .txByte   (txByte),
    .dout     (dout),
    .doutEn   (doutEn),
    .rxByte   (rxByte),
    .rxValid  (rxValid)
  );

endmodule

// File: rtl/pcm_strobe_port_chk.sv
module pcm_strobe_port_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       bclk,
  input logic       stb,
  input logic       dout,
  input logic       doutEn,
  input logic [7:0] rxByte,
  input logic       rxValid
);

  logic [3:0] upCnt;

  always_ff @(posedge clk) begin
    if (rst) upCnt <= '0;
    else if (upCnt != 4'hF) upCnt <= upCnt + 1'b1;
  end

  // R9: reset leaves the port idle
  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (!doutEn && !rxValid));

  // R3: enable follows the strobe after the synchronizer latency
  p_enable_tracks_r3: assert property (@(posedge clk) disable iff (rst)
    (upCnt > 4'(SYNC_STAGES + 2)) |-> (doutEn == $past(stb, SYNC_STAGES + 1)));

  // R3: nothing on the data line while not driving
  p_quiet_line_r3: assert property (@(posedge clk) disable iff (rst)
    !doutEn |-> !dout);

  // R2: output bit moves only after the bit clock went high
  p_shift_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (upCnt > 4'(SYNC_STAGES + 2) && doutEn && $past(doutEn) && (dout != $past(dout)))
      |-> $past(bclk, SYNC_STAGES + 1));

  // R8: delivery pulse lasts one cycle and comes after the window closed
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  p_pulse_outside_r8: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> !doutEn);

  // R10: received byte holds between pulses
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (upCnt != 4'h0 && !rxValid) |-> $stable(rxByte));

endmodule

bind pcm_strobe_port pcm_strobe_port_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .bclk   (bclk),
  .stb    (stb),
  .dout   (dout),
  .doutEn (doutEn),
  .rxByte (rxByte),
  .rxValid(rxValid)
);

// File: tb/pcm_strobe_port_bench.sv
module pcm_strobe_port_bench;

  localparam int HALF = 8;  // system clocks per bit-clock half period

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk = 1'b0, stb = 1'b0, din = 1'b0;
  logic       asyncMode = 1'b0, aLaw = 1'b0, txMute = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic       dout, doutEn, rxValid;
  logic [7:0] rxByte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] txPrev, rxPrev;

  always #2.5 clk = ~clk;

  pcm_strobe_port u_pcm_strobe_port (
    .clk(clk), .rst(rst), .bclk(bclk), .stb(stb), .din(din),
    .asyncMode(asyncMode), .aLaw(aLaw), .txMute(txMute), .txByte(txByte),
    .dout(dout), .doutEn(doutEn), .rxByte(rxByte), .rxValid(rxValid)
  );

  function automatic logic [7:0] quietOf(input logic law);
    return law ? 8'hD5 : 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for delivered bytes
  always @(negedge clk) begin
    if (!rst && rxValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R8 unexpected rxValid", rxByte, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(rxByte == e, t, rxByte, e);
      end
    end
  end

  task automatic doReset(input logic law);
    rst = 1'b1; aLaw = law; stb = 1'b1;
    repeat (6) @(negedge clk);
    chk(doutEn == 1'b0, "R9 enable in reset", doutEn, 0);
    chk(rxValid == 1'b0, "R9 valid in reset", rxValid, 0);
    chk(rxByte == quietOf(law), "R9 rxByte quiet in reset", rxByte, quietOf(law));
    stb = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    txPrev = quietOf(law);
    rxPrev = quietOf(law);
    repeat (4) @(negedge clk);
  endtask

  // one strobe window of nBits bit periods
  task automatic window(input logic [7:0] core, input logic mute, input int nBits,
                        input logic [7:0] rxBits, input string tag);
    logic [7:0] expTx;
    logic [7:0] q;
    q = quietOf(aLaw);
    if (mute)           expTx = q;
    else if (asyncMode) expTx = txPrev;
    else                expTx = core;
    txPrev = core;
    txByte = core; txMute = mute;
    if (nBits >= 8) begin
      expQ.push_back(asyncMode ? rxPrev : rxBits);
      tagQ.push_back({tag, " rx byte R1"});
      rxPrev = rxBits;
    end
    for (int i = 0; i < nBits; i++) begin
      bclk = 1'b1; stb = 1'b1;
      din = (i < 8) ? rxBits[7-i] : ~rxBits[0];
      repeat (HALF) @(negedge clk);
      chk(doutEn == 1'b1, {tag, " R3 enable in window"}, doutEn, 1);
      if (i < 8)
        chk(dout == expTx[7-i], {tag, " R2 tx bit"}, dout, expTx[7-i]);
      else
        chk(dout == q[0], {tag, " R7 tx bit past eighth"}, dout, q[0]);
      bclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    bclk = 1'b1; stb = 1'b0;
    repeat (HALF) @(negedge clk);
    chk(doutEn == 1'b0 && dout == 1'b0, {tag, " R3 idle after window"}, {doutEn, dout}, 0);
    bclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    doReset(1'b1);
    doReset(1'b0);

    // synchronous mode, R4
    asyncMode = 1'b0;
    window(8'hA5, 1'b0, 8, 8'h3C, "R4 sync a");
    window(8'h0F, 1'b0, 8, 8'hC3, "R4 sync b");
    // mute under both laws, R6
    window(8'h81, 1'b1, 8, 8'h96, "R6 mute mu");
    aLaw = 1'b1;
    window(8'h81, 1'b1, 8, 8'h69, "R6 mute A");
    // long window, R7
    window(8'h5A, 1'b0, 10, 8'hE7, "R7 long");
    aLaw = 1'b0;
    // partial window discarded, R8
    window(8'hF0, 1'b0, 5, 8'h12, "R8 partial sync");
    window(8'h24, 1'b0, 8, 8'h42, "R8 after partial");

    // asynchronous mode from reset, R5 and R9
    doReset(1'b0);
    asyncMode = 1'b1;
    window(8'h11, 1'b0, 8, 8'h22, "R9 async first");
    window(8'h33, 1'b0, 8, 8'h44, "R5 async b");
    window(8'h55, 1'b0, 5, 8'h66, "R8 partial async");
    window(8'h77, 1'b0, 8, 8'h88, "R5 async after partial");
    aLaw = 1'b1;
    window(8'h99, 1'b1, 8, 8'hAA, "R6 async mute");
    window(8'hBB, 1'b0, 8, 8'hCC, "R5 async hold through mute");

    repeat (20) @(negedge clk);
    chk(expQ.size() == 0, "R8 all deliveries seen", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule